// File: doc/BRIEF.md
# Halfword DRAM Word Access Sequencer

This block connects a 32-bit processor bus to a DRAM bank whose data path is only 16 bits wide. Every 32-bit word transfer becomes two halfword column cycles. The upper 16 bits of a word live at the lower halfword location and the lower 16 bits at the next one, and the upper half is always moved first. A byte transfer needs only one column cycle. The column address LSB picks the halfword, and one of two active-low CAS strobes picks the byte lane.

A transfer that is not sequential first precharges (RAS high), then opens the row, then runs its column cycles. A sequential word transfer that falls in the row that is still open skips the precharge and row phases. It costs two cycles per halfword. When the sequential address moves into another row, that is when it crosses a page boundary, the block falls back to a full precharge and row open. After any access the row stays open (RAS held low) until the next non-sequential access. Read data is returned as one packed 32-bit word, and ready is raised in the strobe cycle of the final halfword.

A request is accepted only while the sequencer is idle. The bus holds its request fields stable until that acceptance edge.

Top module: `hw_word_seq`

## Requirements
- R1: While reset is asserted, ras_n=1, cas_n=2'b11, we_n=1, dq_oe=0 and ready=0.
- R2: A word at byte address A stores bits 31:16 at halfword index {A[ADDR_W-1:2],0} and bits 15:0 at index {A[ADDR_W-1:2],1}. Reads return {first halfword, second halfword}. The column is halfword index bits COL_W-1:0 and the row is the bits above them.
- R3: A non-sequential word access takes PRE_CYC+RCD_CYC+4 cycles, which is 7 by default. First come PRE_CYC cycles with ras_n=1. Then come RCD_CYC cycles with ras_n=0 and the row on dram_a. Then come two column slots of 2 cycles each: the column on dram_a with CAS high, then CAS low. ready=1 only in the final CAS-low cycle.
- R4: A word request with req_seq=1 whose row equals the open row goes straight to the column slots. It takes 4 cycles, 2 per halfword, with ras_n held low.
- R5: A sequential word request to a different row, or issued with no row open, performs the full precharge and row sequence of R3.
- R6: A byte access is always non-sequential, even with req_seq=1. It takes PRE_CYC+RCD_CYC+2 cycles (5 by default) with one column slot. Its column LSB is ~A[1]. Exactly one strobe goes low: cas_n=2'b01 (lane 15:8) when A[0]=1, and cas_n=2'b10 (lane 7:0) when A[0]=0.
- R7: A byte read returns the addressed byte in rdata bits 8*A[1:0]+7 down to 8*A[1:0], with all other bits 0. A byte write changes only that byte in DRAM.
- R8: During the column slots of a write, we_n=0 and dq_oe=1. dq_out holds the halfword being written, or for a byte write the byte copied onto both lanes. At all other times we_n=1 and dq_oe=0.
- R9: CAS strobes are active low and are only asserted while ras_n=0. In a word's column cycles both strobes go low together (cas_n=2'b00).
- R10: After an access completes, ras_n stays low while idle, holding the row open for later sequential requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, sampled while idle |
| req_seq | input | 1 | Request is sequential to the previous one |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, byte n in bits 8n+7:8n |
| ready | output | 1 | Transfer completes in this cycle |
| rdata | output | 32 | Read data, valid with ready |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, bit 1 = lane 15:8, bit 0 = lane 7:0 |
| we_n | output | 1 | DRAM write enable, active low |
| dram_a | output | DA_W | Multiplexed row/column address |
| dq_out | output | 16 | Data to DRAM |
| dq_oe | output | 1 | DRAM data drive enable |
| dq_in | input | 16 | Data from DRAM |

## Verification
The bench builds the block with ADDR_W=12 and COL_W=3, which gives a page of eight halfwords (four words). With so small a page, a short sequential run of word reads and writes reaches a page crossing and must reopen a row. PRE_CYC=2 and RCD_CYC=1 keep the default timing, so the cycle counts of 7, 4 and 5 are checked exactly. A 2048-halfword array in the bench models the DRAM, so packing order and the bytes that neighbour a byte write can be observed at the DRAM side.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ROW  = 3'd2,
    ST_COLA = 3'd3,
    ST_COLB = 3'd4
  } seq_st_e;

  // Halfword offset of the first column slot: words start at the upper half
  // (lower location), bytes pick the half holding them.
  function automatic logic first_half(input logic is_byte, input logic a1);
    return is_byte ? ~a1 : 1'b0;
  endfunction

  // Active-low strobe pattern for the CAS-low cycle.
  function automatic logic [1:0] strobe_n(input logic is_byte, input logic a0);
    if (!is_byte) return 2'b00;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  // A slot is the last of its transfer for bytes or for the second word half.
  function automatic logic last_slot(input logic is_byte, input logic half);
    return is_byte | half;
  endfunction

  // Data presented to DRAM for one slot.
  function automatic logic [15:0] wr_half(input logic is_byte, input logic [1:0] bsel,
                                          input logic half, input logic [31:0] wd);
    logic [7:0] b;
    b = 8'(wd >> (8 * bsel));
    if (is_byte) return {b, b};
    return half ? wd[15:0] : wd[31:16];
  endfunction

  // Byte read result placed in its own lane of the 32-bit word.
  function automatic logic [31:0] rd_byte(input logic [1:0] bsel, input logic [15:0] hw);
    logic [7:0] b;
    b = bsel[0] ? hw[15:8] : hw[7:0];
    return {24'b0, b} << (8 * bsel);
  endfunction

endpackage

// File: rtl/hwseq_timer.sv
module hwseq_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hwseq_addr.sv
module hwseq_addr #(
  parameter int ADDR_W = 25,
  parameter int COL_W  = 10,
  parameter int ROW_W  = ADDR_W - 1 - COL_W,
  parameter int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [ADDR_W-3:0] wbase,
  input  logic              half,
  input  logic              sel_row,
  output logic [ROW_W-1:0]  row,
  output logic [DA_W-1:0]   dram_a
);
  localparam int HW_W = ADDR_W - 1;

  logic [HW_W-1:0]  hw;
  logic [COL_W-1:0] col;

  assign hw     = {wbase, half};
  assign col    = hw[COL_W-1:0];
  assign row    = hw[HW_W-1:COL_W];
  assign dram_a = sel_row ? DA_W'(row) : DA_W'(col);
endmodule

// File: rtl/hwseq_pack.sv
module hwseq_pack
  import hwseq_pkg::*;
(
  input  logic        is_byte,
  input  logic [1:0]  bsel,
  input  logic        half,
  input  logic [31:0] wdata,
  input  logic [15:0] dq_in,
  input  logic [15:0] upper,
  output logic [15:0] dq_out,
  output logic [31:0] rdata
);
  assign dq_out = wr_half(is_byte, bsel, half, wdata);
  assign rdata  = is_byte ? rd_byte(bsel, dq_in) : {upper, dq_in};
endmodule

// File: rtl/hw_word_seq.sv
module hw_word_seq
  import hwseq_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int COL_W   = 10,
  parameter int PRE_CYC = 2,
  parameter int RCD_CYC = 1,
  localparam int ROW_W  = ADDR_W - 1 - COL_W,
  localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_seq,
  input  logic              req_wr,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              ready,
  output logic [31:0]       rdata,
  output logic              ras_n,
  output logic [1:0]        cas_n,
  output logic              we_n,
  output logic [DA_W-1:0]   dram_a,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  input  logic [15:0]       dq_in
);
  localparam int MAX_PH = (PRE_CYC > RCD_CYC) ? PRE_CYC : RCD_CYC;
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  seq_st_e            st;
  logic               op_wr, op_byte, half, page_open;
  logic [1:0]         op_bsel;
  logic [ADDR_W-3:0]  op_wbase;
  logic [ROW_W-1:0]   open_row, op_row, in_row;
  logic [15:0]        upper_q;
  logic [31:0]        wdata_q;
  logic [CNT_W-1:0]   cnt;

  // Named internal events, also used by the bound checker.
  logic ev_accept, ev_fast, pre_done, row_done, in_col, last, st_idle;

  assign st_idle   = (st == ST_IDLE);
  assign in_row    = req_addr[ADDR_W-1 -: ROW_W];
  assign ev_accept = st_idle && req;
  assign ev_fast   = ev_accept && req_seq && !req_byte && page_open && (in_row == open_row);
  assign pre_done  = (st == ST_PRE) && (cnt == CNT_W'(PRE_CYC - 1));
  assign row_done  = (st == ST_ROW) && (cnt == CNT_W'(RCD_CYC - 1));
  assign in_col    = (st == ST_COLA) || (st == ST_COLB);
  assign last      = last_slot(op_byte, half);

  hwseq_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_accept | pre_done | row_done),
    .cnt   (cnt)
  );

  hwseq_addr #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W), .DA_W(DA_W)) u_addr (
    .wbase   (op_wbase),
    .half    (half),
    .sel_row ((st == ST_PRE) || (st == ST_ROW)),
    .row     (op_row),
    .dram_a  (dram_a)
  );

  hwseq_pack u_pack (
    .is_byte (op_byte),
    .bsel    (op_bsel),
    .half    (half),
    .wdata   (wdata_q),
    .dq_in   (dq_in),
    .upper   (upper_q),
    .dq_out  (dq_out),
    .rdata   (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_wr     <= 1'b0;
      op_byte   <= 1'b0;
      op_bsel   <= '0;
      op_wbase  <= '0;
      half      <= 1'b0;
      page_open <= 1'b0;
      open_row  <= '0;
      upper_q   <= '0;
      wdata_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req) begin
            op_wr    <= req_wr;
            op_byte  <= req_byte;
            op_bsel  <= req_addr[1:0];
            op_wbase <= req_addr[ADDR_W-1:2];
            wdata_q  <= req_wdata;
            half     <= first_half(req_byte, req_addr[1]);
            if (ev_fast) begin
              st <= ST_COLA;
            end else begin
              st        <= ST_PRE;
              page_open <= 1'b0;
            end
          end
        end
        ST_PRE: begin
          if (pre_done) begin
            st        <= ST_ROW;
            page_open <= 1'b1;
            open_row  <= op_row;
          end
        end
        ST_ROW: begin
          if (row_done) st <= ST_COLA;
        end
        ST_COLA: st <= ST_COLB;
        ST_COLB: begin
          if (!last) begin
            half    <= 1'b1;
            upper_q <= dq_in;
            st      <= ST_COLA;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ras_n = ~page_open;
  assign cas_n = (st == ST_COLB) ? strobe_n(op_byte, op_bsel[0]) : 2'b11;
  assign we_n  = ~(op_wr && in_col);
  assign dq_oe = op_wr && in_col;
  assign ready = (st == ST_COLB) && last;

endmodule

// File: rtl/hwseq_chk.sv
module hwseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic       we_n,
  input logic       dq_oe,
  input logic       ready,
  input logic       ev_accept,
  input logic       ev_fast,
  input logic       op_byte,
  input logic       st_idle
);
  // R9
  cas_only_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != 2'b11) |-> !ras_n);

  // R3
  ready_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cas_n != 2'b11));

  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_byte && cas_n != 2'b11) |-> ($countones(cas_n) == 1));

  // R9
  word_both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_byte && cas_n != 2'b11) |-> (cas_n == 2'b00));

  // R5
  precharge_on_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_fast) |=> ras_n);

  // R4
  fast_skips_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast |=> (!ras_n && cas_n == 2'b11));

  // R8
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && !ras_n));

  // R10
  page_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && $past(ready)) |-> !ras_n);
endmodule

bind hw_word_seq hwseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .dq_oe     (dq_oe),
  .ready     (ready),
  .ev_accept (ev_accept),
  .ev_fast   (ev_fast),
  .op_byte   (op_byte),
  .st_idle   (st_idle)
);

// File: tb/hw_word_seq_bench.sv
module hw_word_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int CW   = 3;
  localparam int PRE  = 2;
  localparam int RCD  = 1;
  localparam int RW   = AW - 1 - CW;
  localparam int DW   = (RW > CW) ? RW : CW;
  localparam int HW_N = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_seq = 1'b0, req_wr = 1'b0, req_byte = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          ready, ras_n, we_n, dq_oe;
  logic [31:0]   rdata;
  logic [1:0]    cas_n;
  logic [DW-1:0] dram_a;
  logic [15:0]   dq_out, dq_in;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit run = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_word_seq #(.ADDR_W(AW), .COL_W(CW), .PRE_CYC(PRE), .RCD_CYC(RCD)) u_hw_word_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_seq(req_seq), .req_wr(req_wr),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .rdata(rdata), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dram_a(dram_a), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // ---------------- DRAM model ----------------
  logic [15:0]   mem  [HW_N];
  logic [15:0]   gmem [HW_N];
  logic [RW-1:0] row_l;
  logic          ras_q;
  logic [AW-2:0] midx;

  assign midx  = {row_l, dram_a[CW-1:0]};
  assign dq_in = (cas_n != 2'b11) ? mem[midx] : 16'h0000;

  function automatic logic [15:0] seed(input int i);
    return 16'(i * 40503) ^ 16'h5a5a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HW_N; i++) mem[i] <= seed(i);
      ras_q <= 1'b1;
      row_l <= '0;
    end else begin
      if (!ras_n && ras_q) row_l <= dram_a[RW-1:0];
      ras_q <= ras_n;
      if (cas_n != 2'b11 && !we_n) begin
        if (!cas_n[0]) mem[midx][7:0]  <= dq_out[7:0];
        if (!cas_n[1]) mem[midx][15:8] <= dq_out[15:8];
      end
    end
  end

  // ---------------- Reference model ----------------
  typedef struct {
    logic        ras;
    logic [1:0]  cas;
    logic        we;
    logic        chk_a;
    logic [DW-1:0] a;
    logic        rdy;
    logic        chk_o;
    logic [15:0] o;
    logic        chk_d;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t          q[$];
  bit            m_open = 0;
  logic [RW-1:0] m_row = '0;

  function automatic logic [AW-2:0] hw_of(input logic [AW-1:0] a, input logic k);
    return {a[AW-1:2], k};
  endfunction

  always @(negedge clk) begin
    if (run && !finished) begin
      exp_t e;
      bit bad;
      vectors++;
      if (q.size() != 0) begin
        e = q.pop_front();
        bad = (ras_n !== e.ras) || (cas_n !== e.cas) || (we_n !== e.we) ||
              (dq_oe !== ~e.we) || (ready !== e.rdy) ||
              (e.chk_a && dram_a !== e.a) || (e.chk_o && dq_out !== e.o) ||
              (e.chk_d && rdata !== e.d);
        if (bad) begin
          fails++;
          $display("FAIL %s t=%0t ras_n=%b/%b cas_n=%b/%b we_n=%b/%b rdy=%b/%b a=%h/%h dq_out=%h/%h rdata=%h/%h",
                   e.tag, $time, ras_n, e.ras, cas_n, e.cas, we_n, e.we, ready, e.rdy,
                   dram_a, e.a, dq_out, e.o, rdata, e.d);
        end
      end else begin
        // R10: idle cycles hold the row open once any access has run
        if (ras_n !== ~m_open || cas_n !== 2'b11 || we_n !== 1'b1 || ready !== 1'b0) begin
          fails++;
          $display("FAIL R10 idle t=%0t ras_n=%b/%b cas_n=%b/11 we_n=%b/1 ready=%b/0",
                   $time, ras_n, ~m_open, cas_n, we_n, ready);
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", msg, act, expv);
    end
  endtask

  // Called just after a negedge with the design idle.
  task automatic do_op(input bit wr, input bit isb, input bit seq, input logic [AW-1:0] a,
                       input logic [31:0] wd, input string tag);
    exp_t e;
    bit fast;
    int nslot, lat, exp_lat;
    logic [AW-2:0] h;
    logic [15:0] hv;
    logic [31:0] rexp;
    logic [7:0] bv;
    fast  = seq && !isb && m_open && (a[AW-1 -: RW] == m_row);
    nslot = isb ? 1 : 2;
    exp_lat = fast ? 2*nslot : PRE + RCD + 2*nslot;
    rexp = isb ? (32'((a[0] ? gmem[hw_of(a, ~a[1])][15:8] : gmem[hw_of(a, ~a[1])][7:0])) << (8*a[1:0]))
               : {gmem[hw_of(a,1'b0)], gmem[hw_of(a,1'b1)]};
    bv = 8'(wd >> (8*a[1:0]));
    e.tag = tag; e.chk_o = 0; e.o = '0; e.chk_d = 0; e.d = '0; e.rdy = 0;
    if (!fast) begin
      for (int i = 0; i < PRE; i++) begin
        e.ras = 1; e.cas = 2'b11; e.we = 1; e.chk_a = 0; e.a = '0; q.push_back(e);
      end
      for (int i = 0; i < RCD; i++) begin
        e.ras = 0; e.cas = 2'b11; e.we = 1; e.chk_a = 1; e.a = DW'(a[AW-1 -: RW]); q.push_back(e);
      end
    end
    for (int s = 0; s < nslot; s++) begin
      h = isb ? hw_of(a, ~a[1]) : hw_of(a, 1'(s));
      e.ras = 0; e.cas = 2'b11; e.we = ~wr; e.chk_a = 1; e.a = DW'(h[CW-1:0]);
      e.rdy = 0; e.chk_o = 0; e.chk_d = 0;
      q.push_back(e);
      e.cas = isb ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
      e.rdy = (s == nslot - 1);
      e.chk_o = wr;
      e.o = isb ? {bv, bv} : (s == 0 ? wd[31:16] : wd[15:0]);
      e.chk_d = e.rdy && !wr;
      e.d = rexp;
      q.push_back(e);
    end
    m_open = 1;
    m_row  = a[AW-1 -: RW];
    if (wr) begin
      if (isb) begin
        h = hw_of(a, ~a[1]);
        hv = gmem[h];
        if (a[0]) hv[15:8] = bv; else hv[7:0] = bv;
        gmem[h] = hv;
      end else begin
        gmem[hw_of(a,1'b0)] = wd[31:16];
        gmem[hw_of(a,1'b1)] = wd[15:0];
      end
    end
    req = 1; req_seq = seq; req_wr = wr; req_byte = isb; req_addr = a; req_wdata = wd;
    @(negedge clk); #1;
    req = 0;
    lat = 1;
    while (ready !== 1'b1 && lat < 64) begin
      @(negedge clk); #1;
      lat++;
    end
    check(lat == exp_lat, $sformatf("%s latency", tag), 32'(lat), 32'(exp_lat));
    @(negedge clk); #1;
    if (wr) begin
      // R2, R7: DRAM contents after a write, including untouched neighbour bytes
      for (int k = 0; k < 2; k++) begin
        h = hw_of(a, 1'(k));
        check(mem[h] === gmem[h], $sformatf("%s dram[%0d]", tag, h), 32'(mem[h]), 32'(gmem[h]));
      end
    end
  endtask

  // ---------------- Stimulus ----------------
  initial begin
    for (int i = 0; i < HW_N; i++) gmem[i] = seed(i);
    repeat (3) @(negedge clk);
    #1;
    // R1
    check(ras_n === 1'b1, "R1 ras_n in reset", 32'(ras_n), 32'd1);
    check(cas_n === 2'b11, "R1 cas_n in reset", 32'(cas_n), 32'd3);
    check(we_n === 1'b1 && dq_oe === 1'b0, "R1 we_n/dq_oe in reset", {30'b0, we_n, dq_oe}, 32'h2);
    check(ready === 1'b0, "R1 ready in reset", 32'(ready), 32'd0);
    @(negedge clk);
    rst_n = 1;
    run = 1;
    @(negedge clk); #1;

    do_op(0, 0, 0, 12'h040, 0, "R3 ns word read");
    do_op(0, 0, 1, 12'h044, 0, "R4 seq word read");
    do_op(0, 0, 1, 12'h048, 0, "R4 seq word read 2");
    do_op(0, 0, 1, 12'h04C, 0, "R4 seq word read 3");
    do_op(0, 0, 1, 12'h050, 0, "R5 seq across page");
    do_op(0, 0, 1, 12'h054, 0, "R4 seq after reopen");
    do_op(1, 0, 0, 12'h100, 32'hA1B2C3D4, "R2 ns word write");
    do_op(1, 0, 1, 12'h104, 32'h0F1E2D3C, "R8 seq word write");
    do_op(0, 0, 0, 12'h100, 0, "R2 word read back");
    do_op(0, 0, 1, 12'h104, 0, "R4 seq read back");
    do_op(0, 1, 0, 12'h201, 0, "R6 byte read lane1");
    do_op(0, 1, 0, 12'h202, 0, "R6 byte read lane2");
    do_op(0, 1, 1, 12'h203, 0, "R6 byte read seq flag");
    do_op(0, 1, 0, 12'h200, 0, "R7 byte read lane0");
    do_op(1, 1, 0, 12'h302, 32'h00770000, "R7 byte write");
    do_op(1, 1, 0, 12'h305, 32'h00009900, "R7 byte write odd");
    do_op(0, 0, 1, 12'h300, 0, "R4 seq word after byte");
    do_op(0, 0, 1, 12'h304, 0, "R2 word with byte merged");
    do_op(0, 0, 1, 12'h7F0, 0, "R5 seq to closed other row");
    do_op(1, 0, 1, 12'h7F4, 32'h13572468, "R9 seq write");
    do_op(0, 0, 0, 12'h7F4, 0, "R2 ns read of write");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule